// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the reservation state of a single core for load-linked / store-conditional sequences. The core's load/store unit pulses one strobe per memory event: an ordinary load, an ordinary store, a load-linked carrying an address and size, or a store-conditional carrying an address and size. The block holds a two-state reservation (open or armed), the tagged address and the recorded access size. It answers each store-conditional with a local pass/fail verdict in the same cycle as the strobe.

The rules are deliberately strict. Any ordinary load or store drops a live reservation. A store-conditional passes only when both the address and the size match exactly. A passing verdict only grants local permission. A separate system-level monitor decides whether memory is actually written. When more than one strobe is raised in a cycle, the block flags a protocol error and acts on the highest-priority event only.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-high reset leaves the monitor open, with tagged address zero and size none (encoding 0). After reset, with all strobes low, the verdict, valid and error outputs are 0.
- R2: A load-linked arms the monitor and records the full address and the size (1 = word, 2 = doubleword) in the next cycle. Any earlier reservation is replaced.
- R3: Whenever the monitor is open, the tagged address reads zero and the size reads none.
- R4: An ordinary load returns an armed monitor to open in the next cycle.
- R5: An ordinary store returns an armed monitor to open in the next cycle.
- R6: A store-conditional on an armed monitor passes only when its address equals the tagged address and its size equals the recorded size. The verdict is high in the strobe's cycle, and the monitor is open in the next cycle.
- R7: A store-conditional on an armed monitor whose address or size differs fails. The reservation stays armed with the same address and size.
- R8: A store-conditional on an open monitor always fails and leaves it open.
- R9: When two or more strobes are high in one cycle, the protocol-error output is high in that cycle. Only the highest-priority event takes effect, in the order store-conditional, load-linked, store, load.
- R10: The verdict-valid output is high exactly in the cycles where the store-conditional strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Ordinary load event |
| st_i | input | 1 | Ordinary store event |
| ll_i | input | 1 | Load-linked event |
| sc_i | input | 1 | Store-conditional event |
| addr_i | input | ADDR_W | Address of a load-linked or store-conditional |
| size_i | input | 2 | Access size: 0 none, 1 word, 2 doubleword |
| sc_valid_o | output | 1 | Verdict is valid this cycle |
| sc_pass_o | output | 1 | Store-conditional passes locally |
| proto_err_o | output | 1 | More than one strobe raised this cycle |
| armed_o | output | 1 | Reservation is armed |
| tag_addr_o | output | ADDR_W | Tagged address |
| tag_size_o | output | 2 | Recorded size |

## Verification
The assertions assume that the size on a load-linked is word or doubleword. They check the effect of a strobe only in cycles where no higher-priority strobe is also raised. The random stimulus draws sizes only from word and doubleword. It draws addresses from a four-entry pool, so exact hits, near misses and size-only misses all occur often. About one cycle in ten raises several strobes on purpose, so the priority order and the error flag are exercised without breaking the assumptions the properties rely on.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        SZ_NONE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } xsize_e;

    typedef enum logic [2:0] {
        EV_IDLE  = 3'd0,
        EV_LOAD  = 3'd1,
        EV_STORE = 3'd2,
        EV_LINK  = 3'd3,
        EV_COND  = 3'd4
    } event_e;

    localparam int NUM_STROBES = 4;

endpackage

// File: rtl/resv_event_arb.sv
module resv_event_arb
    import resv_pkg::*;
(
    input  logic [NUM_STROBES-1:0] strobes_i, // {sc, ll, st, ld}
    output event_e                 event_o,
    output logic                   multi_o
);
    localparam int CNT_W = $clog2(NUM_STROBES + 1);

    logic [CNT_W-1:0] count;

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_STROBES; i++) begin
            count = count + CNT_W'(strobes_i[i]);
        end
    end

    assign multi_o = (count > CNT_W'(1));

    always_comb begin
        if (strobes_i[3])      event_o = EV_COND;
        else if (strobes_i[2]) event_o = EV_LINK;
        else if (strobes_i[1]) event_o = EV_STORE;
        else if (strobes_i[0]) event_o = EV_LOAD;
        else                   event_o = EV_IDLE;
    end

endmodule

// File: rtl/resv_match.sv
module resv_match
    import resv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLICE_W = 8
) (
    input  logic              armed_i,
    input  logic [ADDR_W-1:0] tag_addr_i,
    input  xsize_e            tag_size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  xsize_e            size_i,
    output logic              hit_o
);
    localparam int NSLICE = (ADDR_W + SLICE_W - 1) / SLICE_W;
    localparam int PAD_W  = NSLICE * SLICE_W;

    logic [PAD_W-1:0]  tag_pad, req_pad;
    logic [NSLICE-1:0] slice_eq;

    assign tag_pad = PAD_W'(tag_addr_i);
    assign req_pad = PAD_W'(addr_i);

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        assign slice_eq[g] = (tag_pad[g*SLICE_W +: SLICE_W] == req_pad[g*SLICE_W +: SLICE_W]);
    end

    assign hit_o = armed_i && (&slice_eq) && (tag_size_i == size_i);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic              st_i,
    input  logic              ll_i,
    input  logic              sc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              sc_valid_o,
    output logic              sc_pass_o,
    output logic              proto_err_o,
    output logic              armed_o,
    output logic [ADDR_W-1:0] tag_addr_o,
    output logic [1:0]        tag_size_o
);
    typedef struct packed {
        logic              armed;
        logic [ADDR_W-1:0] addr;
        xsize_e            size;
    } mon_t;

    localparam mon_t MON_CLEAR = '{armed: 1'b0, addr: '0, size: SZ_NONE};

    mon_t   mon_d, mon_q;
    event_e ev;
    logic   multi;
    logic   hit;
    logic   pass_d;

    resv_event_arb u_arb (
        .strobes_i ({sc_i, ll_i, st_i, ld_i}),
        .event_o   (ev),
        .multi_o   (multi)
    );

    resv_match #(.ADDR_W(ADDR_W)) u_match (
        .armed_i    (mon_q.armed),
        .tag_addr_i (mon_q.addr),
        .tag_size_i (mon_q.size),
        .addr_i     (addr_i),
        .size_i     (xsize_e'(size_i)),
        .hit_o      (hit)
    );

    always_comb begin
        mon_d  = mon_q;
        pass_d = 1'b0;
        case (ev)
            EV_COND: begin
                if (hit) begin
                    pass_d = 1'b1;
                    mon_d  = MON_CLEAR;
                end
            end
            EV_LINK: begin
                mon_d.armed = 1'b1;
                mon_d.addr  = addr_i;
                mon_d.size  = xsize_e'(size_i);
            end
            EV_STORE, EV_LOAD: mon_d = MON_CLEAR;
            default: mon_d = mon_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mon_q <= MON_CLEAR;
        else     mon_q <= mon_d;
    end

    assign sc_valid_o  = sc_i;
    assign sc_pass_o   = pass_d;
    assign proto_err_o = multi;
    assign armed_o     = mon_q.armed;
    assign tag_addr_o  = mon_q.addr;
    assign tag_size_o  = mon_q.size;

    AST_LINK_ARMS: assert property (@(posedge clk) disable iff (rst)
        (ll_i && !sc_i) |=> (armed_o && tag_addr_o == $past(addr_i) && tag_size_o == $past(size_i))); // R2
    AST_OPEN_IS_BLANK: assert property (@(posedge clk) disable iff (rst)
        !armed_o |-> (tag_addr_o == '0 && tag_size_o == 2'd0)); // R3
    AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ld_i && !st_i && !ll_i && !sc_i) |=> !armed_o); // R4
    AST_STORE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (st_i && !ll_i && !sc_i) |=> !armed_o); // R5
    AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sc_pass_o |=> !armed_o); // R6
    AST_PASS_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        sc_pass_o |-> (armed_o && addr_i == tag_addr_o && size_i == tag_size_o)); // R6
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sc_i && !sc_pass_o) |=> ($stable(armed_o) && $stable(tag_addr_o) && $stable(tag_size_o))); // R7
    AST_OPEN_FAILS: assert property (@(posedge clk) disable iff (rst)
        (sc_i && !armed_o) |-> !sc_pass_o); // R8
    AST_PASS_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        sc_pass_o |-> sc_valid_o); // R10

endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          ld, st, ll, sc;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic          sc_valid, sc_pass, perr, armed;
    logic [AW-1:0] tag_addr;
    logic [1:0]    tag_size;

    resv_monitor #(.ADDR_W(AW)) u_resv_monitor (
        .clk(clk), .rst(rst), .ld_i(ld), .st_i(st), .ll_i(ll), .sc_i(sc),
        .addr_i(addr), .size_i(size), .sc_valid_o(sc_valid), .sc_pass_o(sc_pass),
        .proto_err_o(perr), .armed_o(armed), .tag_addr_o(tag_addr), .tag_size_o(tag_size)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit m_armed;
    logic [AW-1:0] m_addr;
    logic [1:0] m_size;
    logic [AW-1:0] pool [4] = '{32'h100, 32'h108, 32'h104, 32'h200};

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_pass(input bit c, input logic [AW-1:0] a, input logic [1:0] z);
        return c && m_armed && (a == m_addr) && (z == m_size);
    endfunction

    task automatic model_clear();
        m_armed = 1'b0; m_addr = '0; m_size = 2'd0;
    endtask

    task automatic apply(input bit l, input bit s, input bit k, input bit c,
                         input logic [AW-1:0] a, input logic [1:0] z);
        bit p;
        @(negedge clk);
        check("R2 R3 R4 R5 R7", "armed", longint'(armed), longint'(m_armed));
        check("R2 R3", "tag_addr", longint'(tag_addr), longint'(m_addr));
        check("R2 R3", "tag_size", longint'(tag_size), longint'(m_size));
        ld = l; st = s; ll = k; sc = c; addr = a; size = z;
        #2;
        p = exp_pass(c, a, z);
        check(m_armed ? "R6 R7" : "R8", "sc_pass", longint'(sc_pass), longint'(p));
        check("R10", "sc_valid", longint'(sc_valid), longint'(c));
        check("R9", "proto_err", longint'(perr), longint'((int'(l) + int'(s) + int'(k) + int'(c)) > 1));
        if (c) begin
            if (p) model_clear();
        end else if (k) begin
            m_armed = 1'b1; m_addr = a; m_size = z;
        end else if (s || l) begin
            model_clear();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ld = 0; st = 0; ll = 0; sc = 0; addr = '0; size = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "armed", longint'(armed), 0);
        check("R1", "tag_addr", longint'(tag_addr), 0);
        check("R1", "tag_size", longint'(tag_size), 0);
        check("R1", "sc_pass", longint'(sc_pass), 0);
        check("R1", "sc_valid", longint'(sc_valid), 0);
        check("R1", "proto_err", longint'(perr), 0);
        rst = 1'b0;
        model_clear();
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ld = 0; st = 0; ll = 0; sc = 0; addr = '0; size = '0;
        do_reset();
        // R8: conditional on open monitor
        apply(0, 0, 0, 1, 32'h100, 2'd1);
        // R6: exact match passes then opens
        apply(0, 0, 1, 0, 32'h100, 2'd1);
        apply(0, 0, 0, 1, 32'h100, 2'd1);
        apply(0, 0, 0, 0, 32'h0, 2'd0);
        // R7: size miss and address miss keep reservation
        apply(0, 0, 1, 0, 32'h100, 2'd1);
        apply(0, 0, 0, 1, 32'h100, 2'd2);
        apply(0, 0, 0, 1, 32'h104, 2'd1);
        apply(0, 0, 0, 1, 32'h100, 2'd1);
        // R2: later link replaces earlier one
        apply(0, 0, 1, 0, 32'h100, 2'd1);
        apply(0, 0, 1, 0, 32'h200, 2'd2);
        apply(0, 0, 0, 1, 32'h100, 2'd1);
        apply(0, 0, 0, 1, 32'h200, 2'd2);
        // R4: plain load drops reservation
        apply(0, 0, 1, 0, 32'h108, 2'd2);
        apply(1, 0, 0, 0, 32'h0, 2'd0);
        apply(0, 0, 0, 1, 32'h108, 2'd2);
        // R5: plain store drops reservation
        apply(0, 0, 1, 0, 32'h108, 2'd2);
        apply(0, 1, 0, 0, 32'h0, 2'd0);
        apply(0, 0, 0, 1, 32'h108, 2'd2);
        // R9: conditional beats link, link beats store, store beats load
        apply(0, 0, 1, 0, 32'h100, 2'd1);
        apply(0, 0, 1, 1, 32'h100, 2'd1);
        apply(0, 1, 1, 0, 32'h200, 2'd1);
        apply(1, 1, 0, 0, 32'h0, 2'd0);
        apply(1, 1, 1, 1, 32'h200, 2'd1);
        // R1: reset while armed
        apply(0, 0, 1, 0, 32'h104, 2'd1);
        do_reset();
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit l, s, k, c;
            int r = int'($urandom_range(0, 99));
            l = 0; s = 0; k = 0; c = 0;
            if (r < 10) begin
                l = 1'($urandom); s = 1'($urandom); k = 1'($urandom); c = 1'($urandom);
            end else if (r < 18) l = 1;
            else if (r < 26) s = 1;
            else if (r < 58) k = 1;
            else if (r < 95) c = 1;
            apply(l, s, k, c, pool[$urandom_range(0, 3)], 2'($urandom_range(1, 2)));
        end
        apply(0, 0, 0, 0, 32'h0, 2'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule